// File: doc/BRIEF.md
# Single-Cycle Instruction Control Decoder

This block turns the opcode and function fields of a 32-bit instruction into the steering and enable signals that a single-cycle datapath needs within the same clock period. It is purely combinational. Its outputs settle from its two inputs after a fixed logic delay. It has no valid/ready handshake, because it carries no data stream. Every pin is a plain control level that the surrounding datapath samples together with its own state.

The decode runs in two levels. A main decoder looks only at the 6-bit opcode. It produces the register-file and memory enables, the operand and write-back selects, the branch and jump flags, and a 2-bit operation class. An arithmetic decoder then resolves that class into the 3-bit function code of the ALU:
- Class 00 means add.
- Any class with bit 0 set means subtract.
- Class 10 means that the 6-bit function field chooses the operation.

The supported set covers five register-register operations: add, subtract, and, or and set-less-than. It also covers load word, store word, branch-if-equal, add-immediate and the absolute jump.

Top module: `sc_ctrl_decoder`

## Requirements
- R1: Opcode 000000 (register-register) gives rf_we=1, dst_sel_rd=1, alu_b_imm=0, wb_from_mem=0, mem_we=0, br_en=0 and jmp_en=0.
- R2: For opcode 000000, the function field selects alu_fn as follows: 100000 gives 010 (add), 100010 gives 110 (subtract), 100100 gives 000 (and), 100101 gives 001 (or), and 101010 gives 111 (set-less-than).
- R3: For opcode 000000, any other function value gives alu_fn=011, the unused ALU code.
- R4: Opcode 100011 (load) gives rf_we=1, dst_sel_rd=0, alu_b_imm=1, wb_from_mem=1, mem_we=0, br_en=0, jmp_en=0 and alu_fn=010.
- R5: Opcode 101011 (store) gives mem_we=1, rf_we=0, alu_b_imm=1, wb_from_mem=0, dst_sel_rd=0, br_en=0, jmp_en=0 and alu_fn=010.
- R6: Opcode 000100 (branch-if-equal) gives br_en=1, rf_we=0, mem_we=0, alu_b_imm=0, wb_from_mem=0, dst_sel_rd=0, jmp_en=0 and alu_fn=110.
- R7: Opcode 001000 (add-immediate) gives rf_we=1, dst_sel_rd=0, alu_b_imm=1, wb_from_mem=0, mem_we=0, br_en=0, jmp_en=0 and alu_fn=010.
- R8: Opcode 000010 (jump) gives jmp_en=1, with every other flag and select at 0 and alu_fn=010.
- R9: Any other opcode drives every enable, select, br_en and jmp_en to 0, and alu_fn to 010.
- R10: For every opcode other than 000000, no output depends on the function field.
- R11: At most one of mem_we, br_en and jmp_en is 1 at any time. mem_we is 1 only for store, br_en only for branch, and jmp_en only for jump.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_code | input | 6 | Instruction bits 31:26 |
| fn_code | input | 6 | Instruction bits 5:0, used by register-register operations |
| rf_we | output | 1 | Register file write enable |
| dst_sel_rd | output | 1 | 1: write to the rd field register, 0: write to rt |
| alu_b_imm | output | 1 | 1: the ALU B operand is the sign-extended immediate, 0: it is rt |
| br_en | output | 1 | Conditional branch instruction |
| mem_we | output | 1 | Data memory write enable |
| wb_from_mem | output | 1 | 1: write-back data comes from memory, 0: it comes from the ALU |
| jmp_en | output | 1 | Absolute jump instruction |
| alu_fn | output | 3 | ALU function: 000 and, 001 or, 010 add, 011 unused, 110 subtract, 111 set-less-than |

## Verification
Each of the six listed opcodes is applied once with function fields chosen to tempt a wrong decode. This tells a wrong control bit apart from a wrong operation class. Register-register decode is walked through all 64 function values. That separates the five mapped codes from the fallback code and catches a mapping that aliases two functions. For each non-register opcode, every function value is swept, which shows that the function field leaks into none of the outputs. Every unlisted opcode is also swept, to show that no enable escapes for a stray encoding.

// File: rtl/sc_ctrl_pkg.sv
package sc_ctrl_pkg;
  localparam int OP_W   = 6;
  localparam int FN_W   = 6;
  localparam int AOP_W  = 2;
  localparam int ALUF_W = 3;

  typedef enum logic [OP_W-1:0] {
    OPC_REG  = 6'b000000,
    OPC_JUMP = 6'b000010,
    OPC_BEQ  = 6'b000100,
    OPC_ADDI = 6'b001000,
    OPC_LOAD = 6'b100011,
    OPC_STOR = 6'b101011
  } opc_e;

  typedef enum logic [FN_W-1:0] {
    FN_ADD = 6'b100000,
    FN_SUB = 6'b100010,
    FN_AND = 6'b100100,
    FN_OR  = 6'b100101,
    FN_SLT = 6'b101010
  } fn_e;

  // operation class handed from main decoder to arithmetic decoder
  localparam logic [AOP_W-1:0] CLS_ADD = 2'b00;
  localparam logic [AOP_W-1:0] CLS_SUB = 2'b01;
  localparam logic [AOP_W-1:0] CLS_FN  = 2'b10;

  localparam logic [ALUF_W-1:0] ALU_AND = 3'b000;
  localparam logic [ALUF_W-1:0] ALU_OR  = 3'b001;
  localparam logic [ALUF_W-1:0] ALU_ADD = 3'b010;
  localparam logic [ALUF_W-1:0] ALU_NONE = 3'b011;
  localparam logic [ALUF_W-1:0] ALU_SUB = 3'b110;
  localparam logic [ALUF_W-1:0] ALU_SLT = 3'b111;

  typedef struct packed {
    logic rf_we;
    logic dst_sel_rd;
    logic alu_b_imm;
    logic br_en;
    logic mem_we;
    logic wb_from_mem;
    logic jmp_en;
    logic [AOP_W-1:0] cls;
  } ctrl_t;
endpackage

// File: rtl/sc_main_dec.sv
module sc_main_dec
  import sc_ctrl_pkg::*;
(
  input  logic [OP_W-1:0] op_code,
  output ctrl_t           ctrl
);
  always_comb begin
    ctrl = '0;
    ctrl.cls = CLS_ADD;
    case (op_code)
      OPC_REG: begin
        ctrl.rf_we      = 1'b1;
        ctrl.dst_sel_rd = 1'b1;
        ctrl.cls        = CLS_FN;
      end
      OPC_LOAD: begin
        ctrl.rf_we       = 1'b1;
        ctrl.alu_b_imm   = 1'b1;
        ctrl.wb_from_mem = 1'b1;
      end
      OPC_STOR: begin
        ctrl.mem_we    = 1'b1;
        ctrl.alu_b_imm = 1'b1;
      end
      OPC_BEQ: begin
        ctrl.br_en = 1'b1;
        ctrl.cls   = CLS_SUB;
      end
      OPC_ADDI: begin
        ctrl.rf_we     = 1'b1;
        ctrl.alu_b_imm = 1'b1;
      end
      OPC_JUMP: begin
        ctrl.jmp_en = 1'b1;
      end
      default: ctrl = '0;
    endcase
  end
endmodule

// File: rtl/sc_alu_dec.sv
module sc_alu_dec
  import sc_ctrl_pkg::*;
(
  input  logic [AOP_W-1:0]  cls,
  input  logic [FN_W-1:0]   fn_code,
  output logic [ALUF_W-1:0] alu_fn
);
  always_comb begin
    if (cls[0]) begin
      alu_fn = ALU_SUB;
    end else if (cls[1]) begin
      case (fn_code)
        FN_ADD:  alu_fn = ALU_ADD;
        FN_SUB:  alu_fn = ALU_SUB;
        FN_AND:  alu_fn = ALU_AND;
        FN_OR:   alu_fn = ALU_OR;
        FN_SLT:  alu_fn = ALU_SLT;
        default: alu_fn = ALU_NONE;
      endcase
    end else begin
      alu_fn = ALU_ADD;
    end
  end
endmodule

// File: rtl/sc_ctrl_decoder.sv
module sc_ctrl_decoder
  import sc_ctrl_pkg::*;
(
  input  logic [OP_W-1:0]   op_code,
  input  logic [FN_W-1:0]   fn_code,
  output logic              rf_we,
  output logic              dst_sel_rd,
  output logic              alu_b_imm,
  output logic              br_en,
  output logic              mem_we,
  output logic              wb_from_mem,
  output logic              jmp_en,
  output logic [ALUF_W-1:0] alu_fn
);
  ctrl_t ctl;

  sc_main_dec u_main (
    .op_code (op_code),
    .ctrl    (ctl)
  );

  sc_alu_dec u_alu (
    .cls     (ctl.cls),
    .fn_code (fn_code),
    .alu_fn  (alu_fn)
  );

  assign rf_we       = ctl.rf_we;
  assign dst_sel_rd  = ctl.dst_sel_rd;
  assign alu_b_imm   = ctl.alu_b_imm;
  assign br_en       = ctl.br_en;
  assign mem_we      = ctl.mem_we;
  assign wb_from_mem = ctl.wb_from_mem;
  assign jmp_en      = ctl.jmp_en;
endmodule

// File: rtl/sc_ctrl_decoder_chk.sv
module sc_ctrl_decoder_chk
  import sc_ctrl_pkg::*;
(
  input logic [OP_W-1:0]   op_code,
  input logic [AOP_W-1:0]  cls,
  input logic              rf_we,
  input logic              dst_sel_rd,
  input logic              br_en,
  input logic              mem_we,
  input logic              wb_from_mem,
  input logic              jmp_en,
  input logic [ALUF_W-1:0] alu_fn
);
  always_comb begin
    AST_ONE_FLOW_CHANGE: assert ($onehot0({mem_we, br_en, jmp_en})); // R11
    AST_STORE_ONLY: assert (!mem_we || op_code == OPC_STOR); // R11
    AST_RD_ONLY_REG: assert (!dst_sel_rd || (op_code == OPC_REG && rf_we)); // R1
    AST_LOAD_WRITES: assert (!wb_from_mem || rf_we); // R4
    AST_BRANCH_SUB: assert (!br_en || alu_fn == ALU_SUB); // R6
    AST_SUB_CLASS: assert (!(cls == CLS_SUB) || alu_fn == ALU_SUB); // R6
    AST_JUMP_QUIET: assert (!jmp_en || (!rf_we && !mem_we)); // R8
  end
endmodule

bind sc_ctrl_decoder sc_ctrl_decoder_chk u_chk (
  .op_code     (op_code),
  .cls         (ctl.cls),
  .rf_we       (rf_we),
  .dst_sel_rd  (dst_sel_rd),
  .br_en       (br_en),
  .mem_we      (mem_we),
  .wb_from_mem (wb_from_mem),
  .jmp_en      (jmp_en),
  .alu_fn      (alu_fn)
);

// File: tb/sim_sc_ctrl_decoder.sv
module sim_sc_ctrl_decoder;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic [5:0] op_code = '0;
  logic [5:0] fn_code = '0;
  logic rf_we, dst_sel_rd, alu_b_imm, br_en, mem_we, wb_from_mem, jmp_en;
  logic [2:0] alu_fn;
  int checks = 0;
  int errors = 0;

  sc_ctrl_decoder u0 (
    .op_code(op_code), .fn_code(fn_code), .rf_we(rf_we), .dst_sel_rd(dst_sel_rd),
    .alu_b_imm(alu_b_imm), .br_en(br_en), .mem_we(mem_we), .wb_from_mem(wb_from_mem),
    .jmp_en(jmp_en), .alu_fn(alu_fn)
  );

  // packed view: rf_we dst imm br mem wbm jmp alu_fn[2:0]
  task automatic apply_check(input logic [5:0] op, input logic [5:0] fn,
                             input logic [9:0] exp, input string req);
    logic [9:0] act;
    @(negedge clk);
    op_code = op;
    fn_code = fn;
    #1;
    act = {rf_we, dst_sel_rd, alu_b_imm, br_en, mem_we, wb_from_mem, jmp_en, alu_fn};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s op=%b fn=%b actual=%b expected=%b", req, op, fn, act, exp);
    end
  endtask

  task automatic t_reset;
    // inputs held at zero during reset: register-register with function 000000
    apply_check(6'b000000, 6'b000000, 10'b1100000_011, "R3 reset");
  endtask

  task automatic t_reg;
    for (int f = 0; f < 64; f++) begin
      logic [2:0] e;
      case (6'(f))
        6'b100000: e = 3'b010;
        6'b100010: e = 3'b110;
        6'b100100: e = 3'b000;
        6'b100101: e = 3'b001;
        6'b101010: e = 3'b111;
        default:   e = 3'b011;
      endcase
      apply_check(6'b000000, 6'(f), {7'b1100000, e}, "R1 R2 R3 reg");
    end
  endtask

  task automatic t_fixed(input logic [5:0] op, input logic [9:0] exp, input string req);
    apply_check(op, 6'b101010, exp, req);
    for (int f = 0; f < 64; f++)
      apply_check(op, 6'(f), exp, {req, " R10"});
  endtask

  task automatic t_unknown;
    for (int o = 0; o < 64; o++) begin
      logic [5:0] oc = 6'(o);
      if (oc != 6'b000000 && oc != 6'b100011 && oc != 6'b101011 &&
          oc != 6'b000100 && oc != 6'b001000 && oc != 6'b000010) begin
        apply_check(oc, 6'b100010, 10'b0000000_010, "R9 unknown");
        apply_check(oc, 6'b000000, 10'b0000000_010, "R9 unknown");
      end
    end
  endtask

  task automatic t_exclusive;
    // R11: the three flow/memory flags each belong to one opcode
    apply_check(6'b101011, 6'b100100, 10'b0010100_010, "R11 store");
    apply_check(6'b000100, 6'b100100, 10'b0001000_110, "R11 branch");
    apply_check(6'b000010, 6'b100100, 10'b0000001_010, "R11 jump");
  endtask

  initial begin
    #100000;
    errors++;
    $display("FAIL watchdog all-R actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    t_reset();
    rst = 1'b0;
    t_reg();
    t_fixed(6'b100011, 10'b1010010_010, "R4 load");
    t_fixed(6'b101011, 10'b0010100_010, "R5 store");
    t_fixed(6'b000100, 10'b0001000_110, "R6 branch");
    t_fixed(6'b001000, 10'b1010000_010, "R7 addi");
    t_fixed(6'b000010, 10'b0000001_010, "R8 jump");
    t_unknown();
    t_exclusive();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule